// File: doc/BRIEF.md
# Conversion Start Trigger Selector

This block decides the clock cycle in which an analog-to-digital conversion is launched. Three start sources can launch it: a software strobe, an asynchronous external trigger pin that is active on its falling edge, and an on-chip timer output that is active on its rising edge. A 2-bit source-select field picks which of the two hardware sources may act. The software strobe is accepted in every mode. The block holds that field in a small register with a write strobe. The block emits a one-cycle start request to the conversion sequencer.

Each hardware source is forced to its idle level when it is not selected, and this happens before its edge detector. Because of that, selecting a source that already sits at its active level counts as an edge and gives an immediate start. The select value being written is used in the same cycle as the write, so a change made during a conversion takes effect at once. While the sequencer reports busy, triggers are dropped and are not queued.

Top module: `conv_start_sel`

## Requirements
- R1: After reset, `start_o` is low and the select field read back on `sel_o` is 00.
- R2: A high `sw_start_i` with `busy_i` low makes `start_o` high after the next rising clock edge, for every select code.
- R3: The select code enables hardware sources as follows. With 00 neither the pin nor the timer can start a conversion. With 01 only the pin can. With 10 only the timer can. With 11 both can.
- R4: When the pin is selected, a high-to-low change on `ext_trig_n_i` passes a two-flop synchronizer. `start_o` then rises after the third rising edge at which the pin is sampled low. A pin that stays low does not start again.
- R5: When the timer is selected, a low-to-high change on `timer_i` makes `start_o` high after the first rising edge at which it is sampled high. A timer that stays high does not start again.
- R6: When `sel_we_i` is high, `sel_wdata_i` controls the gating in that same cycle and is stored at the clock edge. When `sel_we_i` is low, the stored value is held.
- R7: Writing a code that selects the pin while the synchronized pin is low, or a code that selects the timer while `timer_i` is high, gives a start after that write's clock edge.
- R8: `start_o` is never high in two consecutive cycles.
- R9: Any trigger seen in a cycle with `busy_i` high is dropped. `start_o` is low after that edge, and the trigger does not produce a start later.
- R10: Sources that trigger in the same cycle produce a single start pulse. Deselecting a source that is at its active level does not produce a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_start_i | input | 1 | Software start strobe, active high |
| ext_trig_n_i | input | 1 | External trigger pin, asynchronous, falling-edge active |
| timer_i | input | 1 | Internal timer output, synchronous, rising-edge active |
| sel_we_i | input | 1 | Write strobe for the source-select field |
| sel_wdata_i | input | 2 | New source-select value (bit 0 enables the pin, bit 1 enables the timer) |
| busy_i | input | 1 | Conversion in progress; triggers are dropped while high |
| sel_o | output | 2 | Stored source-select value |
| start_o | output | 1 | One-cycle conversion start request |

## Verification
A wrong idle level in one of the edge-detector history flops, or in the synchronizer flops, appears as a spurious start. It shows up one edge after reset, or at the first select write, and is easy to miss unless `start_o` is compared on every cycle. A stale select register shows as a start that is missing or extra on the next hardware edge. A broken pipeline depth moves the pin-triggered start by whole cycles. For those reasons the bench compares `start_o` against a cycle-exact reference after every edge. Directed writes made while a source sits at its active level then confirm that the gating comes before the edge detector.

// File: rtl/conv_trig_pkg.sv
// Package: shared widths, select-code type and decode helpers for the
// conversion start selector. Assumes bit 0 of the code enables the pin
// and bit 1 enables the timer.
package conv_trig_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_SW_ONLY = 2'b00,
        SRC_PIN     = 2'b01,
        SRC_TIMER   = 2'b10,
        SRC_ALL     = 2'b11
    } src_sel_e;

    localparam int PIN_BIT   = 0;
    localparam int TIMER_BIT = 1;

    function automatic logic pin_enabled(input logic [SEL_W-1:0] code);
        return code[PIN_BIT];
    endfunction

    function automatic logic timer_enabled(input logic [SEL_W-1:0] code);
        return code[TIMER_BIT];
    endfunction

endpackage

// File: rtl/cts_sync.sv
// Module: multi-stage synchronizer for one asynchronous input bit.
// Assumes the destination clock domain is clk. Every stage resets to
// RESET_VAL so that no false edge appears after reset.
module cts_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous bit through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // The output may change only by taking over the value of the stage before it.
    assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_o == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/cts_gated_edge.sv
// Module: gates one synchronous source by an enable and detects its
// active edge. When disabled, the source is forced to its idle level
// before the history flop. Enabling a source that is already at its
// active level therefore shows up as an edge.
// Assumes src_i is synchronous to clk.
module cts_gated_edge #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic enable_i,
    output logic edge_o
);

    localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

    logic gated;
    logic prev_q;

    // Force a deselected source to its idle level.
    always_comb begin
        gated = enable_i ? src_i : IDLE_LVL;
    end

    // Remember the gated level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= IDLE_LVL;
        end else begin
            prev_q <= gated;
        end
    end

    generate
        if (ACTIVE_HIGH) begin : g_rise
            assign edge_o = gated & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~gated & prev_q;
        end
    endgenerate

    // A disabled source can never report an edge.
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !edge_o);

    // An edge cannot repeat in the next cycle while the source is unchanged.
    assert_edge_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && enable_i) |=> (!edge_o || !$stable(src_i) || !$stable(enable_i)));

endmodule

// File: rtl/cts_sel_reg.sv
// Module: holds the source-select field. Provides a write-through view,
// so that the value being written is used by the gating in the same cycle.
// Assumes the write strobe is synchronous to clk.
module cts_sel_reg
    import conv_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wdata_i,
    output logic [SEL_W-1:0] stored_o,
    output logic [SEL_W-1:0] effective_o
);

    src_sel_e sel_q;

    // Store a new select value on a write; reset selects software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SRC_SW_ONLY;
        end else if (we_i) begin
            sel_q <= src_sel_e'(wdata_i);
        end
    end

    // Present the written value in the write cycle itself.
    always_comb begin
        effective_o = we_i ? wdata_i : sel_q;
    end

    assign stored_o = sel_q;

    // Without a write the stored field holds.
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && $past(rst_n)) |=> $stable(stored_o));

    // A write is stored at the edge.
    assert_sel_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (stored_o == $past(wdata_i)));

endmodule

// File: rtl/cts_start_gen.sv
// Module: merges the software strobe and the hardware edges into one
// registered start pulse. Drops requests while busy and never issues
// two pulses in a row. Assumes all request inputs are synchronous to clk.
module cts_start_gen #(
    parameter int N_REQ = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             busy_i,
    output logic             start_o
);

    logic any_req;
    logic start_q;

    // Any enabled source asks for a start; the first one to arrive wins.
    always_comb begin
        any_req = |req_i;
    end

    // Register the start pulse, suppressed while busy or right after a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= any_req & ~busy_i & ~start_q;
        end
    end

    assign start_o = start_q;

    // The start pulse is exactly one cycle wide.
    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // A busy cycle never leads to a start.
    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !start_o);

    // Each start has a request behind it.
    assert_start_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && $past(rst_n)) |-> $past(any_req));

endmodule

// File: rtl/conv_start_sel.sv
// Module: top level of the conversion start selector. Synchronizes the
// external pin, gates the pin and the timer by the select field, detects
// their edges and produces a one-cycle start request.
// Assumes timer_i and busy_i are synchronous to clk. ext_trig_n_i may be
// asynchronous.
module conv_start_sel
    import conv_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start_i,
    input  logic             ext_trig_n_i,
    input  logic             timer_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic             busy_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             start_o
);

    localparam int N_REQ = 3;

    logic [SEL_W-1:0] sel_eff;
    logic             pin_sync;
    logic             pin_fall;
    logic             tmr_rise;
    logic [N_REQ-1:0] req_vec;

    cts_sel_reg u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (sel_we_i),
        .wdata_i     (sel_wdata_i),
        .stored_o    (sel_o),
        .effective_o (sel_eff)
    );

    cts_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_n_i),
        .sync_o  (pin_sync)
    );

    cts_gated_edge #(.ACTIVE_HIGH(1'b0)) u_pin_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (pin_sync),
        .enable_i (pin_enabled(sel_eff)),
        .edge_o   (pin_fall)
    );

    cts_gated_edge #(.ACTIVE_HIGH(1'b1)) u_tmr_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (timer_i),
        .enable_i (timer_enabled(sel_eff)),
        .edge_o   (tmr_rise)
    );

    // Collect the request from every source.
    always_comb begin
        req_vec = {tmr_rise, pin_fall, sw_start_i};
    end

    cts_start_gen #(.N_REQ(N_REQ)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .busy_i  (busy_i),
        .start_o (start_o)
    );

    // With software-only selected, hardware sources alone cause no start.
    assert_sw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_eff == SRC_SW_ONLY && !sw_start_i) |=> !start_o);

    // A software strobe while idle always gives a start unless a pulse is in flight.
    assert_sw_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start_i && !busy_i && !start_o) |=> start_o);

endmodule

// File: tb/conv_start_sel_tb.sv
module conv_start_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_start_i = 1'b0;
    logic       ext_trig_n_i = 1'b1;
    logic       timer_i = 1'b0;
    logic       sel_we_i = 1'b0;
    logic [1:0] sel_wdata_i = 2'b00;
    logic       busy_i = 1'b0;
    logic [1:0] sel_o;
    logic       start_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic m_s1, m_s2, m_pp, m_tp, m_start;
    logic [1:0] m_sel;

    always #10 clk = ~clk;

    conv_start_sel u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_start_i   (sw_start_i),
        .ext_trig_n_i (ext_trig_n_i),
        .timer_i      (timer_i),
        .sel_we_i     (sel_we_i),
        .sel_wdata_i  (sel_wdata_i),
        .busy_i       (busy_i),
        .sel_o        (sel_o),
        .start_o      (start_o)
    );

    function automatic logic exp_start(input logic sw, input logic fall,
                                       input logic rise, input logic busy,
                                       input logic prev_start);
        return (sw | fall | rise) & ~busy & ~prev_start;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 1'b1; m_s2 = 1'b1; m_pp = 1'b1; m_tp = 1'b0;
        m_start = 1'b0; m_sel = 2'b00;
    endtask

    // One clock: compute expectation from pre-edge inputs, then compare.
    task automatic step(input string req);
        logic [1:0] es;
        logic gp, gt, fall, rise;
        es   = sel_we_i ? sel_wdata_i : m_sel;
        gp   = es[0] ? m_s2 : 1'b1;
        gt   = es[1] ? timer_i : 1'b0;
        fall = m_pp & ~gp;
        rise = ~m_tp & gt;
        @(posedge clk);
        m_start = exp_start(sw_start_i, fall, rise, busy_i, m_start);
        m_s2 = m_s1; m_s1 = ext_trig_n_i; m_pp = gp; m_tp = gt;
        if (sel_we_i) m_sel = sel_wdata_i;
        #1;
        check(req, {1'b0, start_o}, {1'b0, m_start});
        @(negedge clk);
    endtask

    task automatic idle();
        sw_start_i = 0; sel_we_i = 0;
    endtask

    task automatic write_sel(input logic [1:0] v, input string req);
        sel_we_i = 1; sel_wdata_i = v;
        step(req);
        sel_we_i = 0;
        check(req, sel_o, v);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", {1'b0, start_o}, 2'b00);
        check("R1", sel_o, 2'b00);
        run(2, "R1");

        // R2 software start in mode 00
        sw_start_i = 1; step("R2"); sw_start_i = 0;
        check("R2", {1'b0, start_o}, 2'b01);
        run(2, "R2");

        // R3 mode 00 ignores pin fall and timer rise
        ext_trig_n_i = 0; timer_i = 1;
        run(5, "R3");
        check("R3", {1'b0, start_o}, 2'b00);
        ext_trig_n_i = 1; timer_i = 0; run(4, "R3");

        // R4 pin falling edge in mode 01: start after third edge
        write_sel(2'b01, "R6");
        run(2, "R4");
        ext_trig_n_i = 0;
        step("R4"); step("R4");
        check("R4", {1'b0, start_o}, 2'b00);
        step("R4");
        check("R4", {1'b0, start_o}, 2'b01);
        run(4, "R4");  // held low: no repeat
        check("R4", {1'b0, start_o}, 2'b00);
        // R3 timer ignored in mode 01
        timer_i = 1; run(3, "R3"); timer_i = 0;
        ext_trig_n_i = 1; run(3, "R4");

        // R5 timer rising in mode 10
        write_sel(2'b10, "R6");
        timer_i = 1; step("R5");
        check("R5", {1'b0, start_o}, 2'b01);
        run(3, "R5");
        check("R5", {1'b0, start_o}, 2'b00);
        timer_i = 0; run(2, "R5");
        // R3 pin ignored in mode 10
        ext_trig_n_i = 0; run(5, "R3");
        check("R3", {1'b0, start_o}, 2'b00);

        // R7 selecting pin while it is low -> immediate start
        write_sel(2'b11, "R7");
        check("R7", {1'b0, start_o}, 2'b01);
        run(2, "R7");
        // R10 deselecting active pin gives no start
        write_sel(2'b10, "R10");
        check("R10", {1'b0, start_o}, 2'b00);
        ext_trig_n_i = 1; run(3, "R10");

        // R7 selecting timer while high
        write_sel(2'b00, "R6");
        timer_i = 1; run(2, "R7");
        write_sel(2'b10, "R7");
        check("R7", {1'b0, start_o}, 2'b01);
        timer_i = 0; run(2, "R7");

        // R9 busy drops a timer edge, no later start
        busy_i = 1; timer_i = 1; step("R9");
        check("R9", {1'b0, start_o}, 2'b00);
        busy_i = 0; run(3, "R9");
        check("R9", {1'b0, start_o}, 2'b00);
        timer_i = 0;

        // R10 simultaneous sources -> one pulse; R8 back-to-back strobes
        write_sel(2'b11, "R6");
        run(2, "R10");
        sw_start_i = 1; timer_i = 1; step("R10");
        check("R10", {1'b0, start_o}, 2'b01);
        step("R8");
        check("R8", {1'b0, start_o}, 2'b00);
        sw_start_i = 0; timer_i = 0; run(3, "R8");

        // random phase against the reference
        for (int i = 0; i < 3000; i++) begin
            sw_start_i   = ($urandom % 10) == 0;
            if (($urandom % 6) == 0) ext_trig_n_i = ~ext_trig_n_i;
            if (($urandom % 5) == 0) timer_i = ~timer_i;
            busy_i       = ($urandom % 4) == 0;
            sel_we_i     = ($urandom % 12) == 0;
            sel_wdata_i  = 2'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10");
            check("R6", sel_o, m_sel);
        end
        idle();
        run(3, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule